// File: doc/BRIEF.md
# I2C Master START Recovery with SDA Unblocking

This block is the part of an I2C master that forms the START condition. When a START is requested and the bus is free, it pulls SDA low while SCL is high, waits half a bit period, and then pulls SCL low. After that, the rest of the controller takes the lines.

If another device holds SDA low when the request arrives, the block cannot form a START. It instead clocks the bus itself, driving extra SCL pulses so that the stuck device can finish its byte and let go of SDA. After each pair of pulses it samples SDA. It forms the START only once SDA reads high. The processor plays no part in this recovery. The block can do nothing about SCL being held low by another device; it reports that condition and waits.

Both lines are open-drain. The block only ever pulls a line low or releases it. It reads the resolved line levels back on `sda_in` and `scl_in`. All bus timing is paced by an external tick that marks each half bit period.

Top module: `i2c_start_recover`

## Requirements
- R1: After reset, both pull enables are 0, `status` is 8'hF8, `start_done` is 0 and `scl_stuck` is 0.
- R2: If SDA reads high when SCL is first seen high after a request, a START is formed with no extra pulses. SDA is pulled while SCL is released, and SCL is pulled exactly one tick interval (half a bit) later.
- R3: While SDA reads low, the block drives SCL pulses. The low half of each pulse lasts exactly one tick interval.
- R4: SDA is checked only at the end of the high half of every second pulse. If the other device lets go of SDA after K pulses, the START follows exactly 2*ceil(K/2) pulses.
- R5: When the START completes, `start_done` is high for one cycle. Both lines then stay pulled and `status` reads 8'h08 until the request is withdrawn.
- R6: A new request made after a completed START (a repeated START) runs the same check-and-pulse sequence again.
- R7: Withdrawing `start_req` at any point releases both lines and returns `status` to 8'hF8 in the next cycle, with no further pulses.
- R8: While SCL reads low even though the block is releasing it, the block drives no pulse and no START. After STUCK_TICKS ticks, `scl_stuck` goes to 1. Once SCL is released, `scl_stuck` clears and the START proceeds.
- R9: The SDA pull for a START begins only while `scl_in` reads high, and SCL stays released in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | START request, held high until served |
| tick | input | 1 | One-cycle pulse marking each half bit period |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| status | output | 8 | 8'h08 after a START, 8'hF8 otherwise |
| start_done | output | 1 | One-cycle pulse when the START is complete |
| scl_stuck | output | 1 | SCL held low by another device |

## Verification
The hardest case to reach is a device that lets go of SDA partway through a pulse pair. That case shows whether the block really waits for the pair to finish before retrying. The bench models the other device as a counter of completed SCL pulses. It releases SDA after a chosen count K, and the runs use K = 0, 1, 3 and 4, so both odd and even release points occur. A separate run holds SCL low from outside before the request. That run checks that no pulse escapes while the clock line is blocked, and that recovery follows the release.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_CHECK,
    RS_PLOW,
    RS_PHIGH,
    RS_HOLD,
    RS_DONE
  } rec_state_e;

  localparam logic [7:0] STAT_NONE  = 8'hF8;
  localparam logic [7:0] STAT_START = 8'h08;
endpackage

// File: rtl/i2c_rec_rst_sync.sv
module i2c_rec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_rec_pair_cnt.sv
module i2c_rec_pair_cnt #(
  parameter int PULSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (PULSES > 1) ? $clog2(PULSES) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == W'(PULSES - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_rec_stuck_mon.sv
module i2c_rec_stuck_mon #(
  parameter int STUCK_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic watch,
  input  logic scl_in,
  output logic stuck
);
  localparam int W = $clog2(STUCK_TICKS + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         stuck_q, stuck_d;
  logic         low_seen;

  assign low_seen = watch && !scl_in;

  always_comb begin
    cnt_d   = cnt_q;
    stuck_d = stuck_q;
    if (!low_seen) begin
      cnt_d   = '0;
      stuck_d = 1'b0;
    end else if (tick) begin
      if (cnt_q != W'(STUCK_TICKS)) cnt_d = cnt_q + 1'b1;
      if (cnt_q == W'(STUCK_TICKS - 1)) stuck_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stuck_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stuck_q <= stuck_d;
    end
  end

  assign stuck = stuck_q;
endmodule

// File: rtl/i2c_rec_fsm.sv
module i2c_rec_fsm
  import i2c_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       tick,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       pair_last,
  output logic       pair_clr,
  output logic       pair_inc,
  output logic       watch,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic [7:0] status,
  output logic       done
);
  rec_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d  = state_q;
    pair_clr = 1'b0;
    pair_inc = 1'b0;
    done_d   = 1'b0;
    if (!start_req) begin
      state_d = RS_IDLE;
    end else begin
      unique case (state_q)
        RS_IDLE:  state_d = RS_CHECK;
        RS_CHECK: if (tick && scl_in) begin
          pair_clr = 1'b1;
          state_d  = sda_in ? RS_HOLD : RS_PLOW;
        end
        RS_PLOW:  if (tick) state_d = RS_PHIGH;
        RS_PHIGH: if (tick && scl_in) begin
          pair_inc = 1'b1;
          if (pair_last && sda_in) state_d = RS_HOLD;
          else                     state_d = RS_PLOW;
        end
        RS_HOLD:  if (tick) begin
          state_d = RS_DONE;
          done_d  = 1'b1;
        end
        RS_DONE:  state_d = RS_DONE;
        default:  state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign scl_pull = (state_q == RS_PLOW) || (state_q == RS_DONE);
  assign sda_pull = (state_q == RS_HOLD) || (state_q == RS_DONE);
  assign watch    = (state_q == RS_CHECK) || (state_q == RS_PHIGH);
  assign status   = (state_q == RS_DONE) ? STAT_START : STAT_NONE;
  assign done     = done_q;
endmodule

// File: rtl/i2c_start_recover.sv
module i2c_start_recover #(
  parameter int PULSES_PER_TRY = 2,
  parameter int STUCK_TICKS    = 8,
  parameter int RST_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       tick,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic [7:0] status,
  output logic       start_done,
  output logic       scl_stuck
);
  logic rst_n_i;
  logic pair_clr, pair_inc, pair_last, watch;

  i2c_rec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  i2c_rec_pair_cnt #(.PULSES(PULSES_PER_TRY)) u_pair (
    .clk(clk), .rst_n(rst_n_i), .clr(pair_clr), .inc(pair_inc), .last(pair_last)
  );

  i2c_rec_stuck_mon #(.STUCK_TICKS(STUCK_TICKS)) u_stuck (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .watch(watch),
    .scl_in(scl_in), .stuck(scl_stuck)
  );

  i2c_rec_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .start_req(start_req), .tick(tick),
    .sda_in(sda_in), .scl_in(scl_in), .pair_last(pair_last),
    .pair_clr(pair_clr), .pair_inc(pair_inc), .watch(watch),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .status(status), .done(start_done)
  );
endmodule

// File: rtl/i2c_rec_chk.sv
module i2c_rec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       scl_in,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [7:0] status,
  input logic       start_done,
  input logic       scl_stuck
);
  // R9
  start_edge_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && !scl_pull) |-> scl_in);

  // R9
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && !scl_pull) |=> !scl_pull);

  // R5
  done_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> (scl_pull && sda_pull && status == 8'h08));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> !start_done);

  // R7
  withdraw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> (!scl_pull && !sda_pull && status == 8'hF8));

  // R8
  stuck_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_stuck |-> !$past(scl_in));
endmodule

bind i2c_start_recover i2c_rec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .scl_in(scl_in),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .status(status),
  .start_done(start_done), .scl_stuck(scl_stuck)
);

// File: tb/test_i2c_start_recover.sv
module test_i2c_start_recover;
  localparam int TICK_DIV = 4;
  localparam int STUCK    = 8;
  localparam logic [1:0] EV_PULSE = 2'd0, EV_START = 2'd1, EV_DONE = 2'd2;

  logic clk, rst_n, start_req, tick, sda_in, scl_in;
  logic scl_pull, sda_pull, start_done, scl_stuck;
  logic [7:0] status;
  logic scl_hold, slave_hold;

  int n_checks, n_fail, cyc, pulse_total, base, slave_k;
  int pulse_start, start_cyc;
  logic in_pulse, prev_scl, prev_sda;
  logic [1:0] exp_q[$];

  i2c_start_recover #(.STUCK_TICKS(STUCK)) i_i2c_start_recover (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
    .sda_in(sda_in), .scl_in(scl_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .status(status), .start_done(start_done), .scl_stuck(scl_stuck)
  );

  assign slave_hold = (pulse_total - base) < slave_k;
  assign sda_in = !(sda_pull || slave_hold);
  assign scl_in = !(scl_pull || scl_hold);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic got(input logic [1:0] ev);
    logic [1:0] e;
    if (exp_q.size() == 0) check(1'b0, "R4 unexpected event", ev, 3);
    else begin
      e = exp_q.pop_front();
      check(e == ev, "R4 event order", ev, e);
    end
  endtask

  // tick source
  initial begin
    int d;
    tick = 1'b0;
    d = 0;
    forever begin
      @(negedge clk);
      tick <= (d == TICK_DIV - 1);
      d = (d == TICK_DIV - 1) ? 0 : d + 1;
    end
  end

  // monitor
  initial begin
    cyc = 0; pulse_total = 0; in_pulse = 1'b0;
    prev_scl = 1'b0; prev_sda = 1'b0; pulse_start = 0; start_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (sda_pull && !prev_sda && !scl_pull) begin
          got(EV_START);
          start_cyc = cyc;
        end
        if (scl_pull && !prev_scl && !sda_pull) begin
          got(EV_PULSE);
          in_pulse = 1'b1;
          pulse_start = cyc;
        end
        if (!scl_pull && prev_scl && in_pulse) begin
          in_pulse = 1'b0;
          pulse_total++;
          // R3 low half is one tick interval
          check(cyc - pulse_start == TICK_DIV, "R3 pulse low width", cyc - pulse_start, TICK_DIV);
        end
        if (start_done) begin
          got(EV_DONE);
          // R2 SDA-to-SCL hold of one tick interval
          check(cyc - start_cyc == TICK_DIV, "R2 start hold", cyc - start_cyc, TICK_DIV);
        end
      end
      prev_scl = scl_pull;
      prev_sda = sda_pull;
    end
  end

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!start_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(start_done == 1'b1, req, start_done, 1);
  endtask

  task automatic run_case(input int k, input string req);
    int np;
    base = pulse_total;
    slave_k = k;
    np = 2 * ((k + 1) / 2);
    for (int i = 0; i < np; i++) exp_q.push_back(EV_PULSE);
    exp_q.push_back(EV_START);
    exp_q.push_back(EV_DONE);
    start_req = 1'b1;
    wait_done(req);
    @(negedge clk);
    // R5 held state after START
    check(status == 8'h08 && scl_pull && sda_pull && !start_done, "R5 held after start", status, 8);
    check(exp_q.size() == 0, "R4 pulse count before start", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    start_req = 1'b0;
    @(negedge clk);
    // R7 release after withdrawal
    check(!scl_pull && !sda_pull && status == 8'hF8, "R7 release", {scl_pull, sda_pull}, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; start_req = 1'b0; scl_hold = 1'b0;
    base = 0; slave_k = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!scl_pull && !sda_pull && status == 8'hF8 && !start_done && !scl_stuck,
          "R1 reset state", status, 8'hF8);

    run_case(0, "R2 free bus start");
    run_case(1, "R4 release after one pulse");
    run_case(3, "R4 release after three pulses");
    run_case(4, "R4 release after four pulses");
    run_case(2, "R6 repeated start");

    // R7 abort mid-recovery
    base = pulse_total;
    slave_k = 1000;
    for (int i = 0; i < 4; i++) exp_q.push_back(EV_PULSE);
    start_req = 1'b1;
    while (pulse_total - base < 4) @(negedge clk);
    start_req = 1'b0;
    @(negedge clk);
    check(!scl_pull && !sda_pull && status == 8'hF8, "R7 abort release", {scl_pull, sda_pull}, 0);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0 && !scl_pull && !sda_pull, "R7 no pulses after abort", exp_q.size(), 0);
    base = pulse_total;
    slave_k = 0;
    repeat (4) @(negedge clk);

    // R8 SCL held low by another device
    scl_hold = 1'b1;
    start_req = 1'b1;
    repeat (60) @(negedge clk);
    check(scl_stuck == 1'b1, "R8 stuck flag", scl_stuck, 1);
    check(!scl_pull && !sda_pull, "R8 no drive while SCL held", {scl_pull, sda_pull}, 0);
    exp_q.push_back(EV_START);
    exp_q.push_back(EV_DONE);
    scl_hold = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(scl_stuck == 1'b0, "R8 stuck clears", scl_stuck, 0);
    wait_done("R8 start after SCL release");
    start_req = 1'b0;
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 events", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule